// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block moves a run of bytes from a source to a destination, one byte at a time. Each byte is a read cycle on the source address followed by a write cycle on the destination address. A simple bus carries both cycles and has separate memory and I/O strobes. Software fills the source address, the destination address, the byte count and a control word through a small write port. Setting the enable bit in the control word starts the run. The sequencer then asks the CPU for the bus with a request/grant handshake and moves bytes until the count runs out.

A four-bit mode field gives each side its own two-bit addressing code: step up, step down, hold on a memory location, or hold on an I/O port. Which code the two sides carry also decides the pacing. A memory-to-memory run has no request line, so a control bit picks one of two pacings. The sequencer either keeps the bus for the whole run, or hands the bus back for one cycle after every byte. Any run that touches I/O space is paced by a level-sensitive external request input.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the channel is disabled and the burst bit, the error flag, bus request, both data strobes, both space strobes and done are all 0.
- R2: The mode field puts the source code in bits [1:0] and the destination code in bits [3:2]. For each code, 00 increments the address by 1, 01 decrements it by 1, 10 holds it fixed in memory space, and 11 holds it fixed in I/O space. After the write of each byte, both addresses step by their codes, modulo 2^20.
- R3: Each byte is one read cycle (read strobe high, source address on the bus) followed directly by one write cycle (write strobe high, destination address, with the data read in the previous cycle). The I/O strobe is high when that side's code is 11 and the memory strobe is high otherwise. The two data strobes are never high together.
- R4: Enabling with mode 1010, 1011, 1110 or 1111 starts no transfer. It raises no bus request, leaves the channel disabled and sets an error flag. The flag stays set until reset, including through later control writes.
- R5: Enabling with a byte count of 0 raises no bus request. Done pulses high for exactly one cycle, and the channel stays disabled.
- R6: Memory-to-memory with the burst bit (control bit 4) at 1 holds bus request continuously from its rise until after the final write. It has exactly one request rise per run.
- R7: Memory-to-memory with the burst bit at 0 drops bus request for exactly one cycle after each byte except the last. A run of N bytes has N request rises.
- R8: When either side is coded 11, the request input paces the run and the burst bit has no effect. While the request input is low before a byte, bus request and all strobes stay low.
- R9: The count drops by 1 on each completed byte. After the byte that brings it to 0, bus request is low, the enable bit (control bit 5) is cleared, and done is high for exactly one cycle.
- R10: While the channel is enabled, writes to the address, count and control registers are ignored.
- R11: No read or write strobe is issued unless bus request and bus grant are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 20 | Write data; control uses [3:0] mode, [4] burst, [5] enable |
| dma_req | input | 1 | Level-sensitive pacing request for I/O runs |
| bus_gnt | input | 1 | Bus grant from the CPU |
| rd_data | input | 8 | Read data returned during a read cycle |
| bus_req | output | 1 | Bus request to the CPU |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_mem | output | 1 | Memory space strobe |
| bus_io | output | 1 | I/O space strobe |
| bus_addr | output | 20 | Cycle address |
| wr_data | output | 8 | Write data |
| done | output | 1 | One-cycle end-of-run pulse |
| enable | output | 1 | Channel enable bit |
| burst_mode | output | 1 | Memory-mode burst bit |
| mode | output | 4 | Transfer mode field |
| mode_err | output | 1 | Sticky reserved-mode error flag |
| src_addr | output | 20 | Current source address |
| dst_addr | output | 20 | Current destination address |
| count | output | 16 | Remaining byte count |

## Verification
A wrong address step or a misdecoded mode code shows up on the bus address or on a space strobe in the read or write cycle of the very next byte. A pacing state that decides wrongly changes the shape of bus request within two cycles of a write: a missing one-cycle gap, an extra gap, or a request raised while the pacing input is low. Counter errors show up as a wrong number of write cycles, or as a done pulse at the wrong time, by the end of a short run. The remaining count and the final addresses then confirm the error at the ports.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_READ,
        ST_WRITE,
        ST_STEAL
    } seq_state_e;

    typedef enum logic [1:0] {
        AM_INC    = 2'b00,
        AM_DEC    = 2'b01,
        AM_FIXMEM = 2'b10,
        AM_FIXIO  = 2'b11
    } addr_mode_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CTRL_BURST_BIT = 4;
    localparam int CTRL_EN_BIT    = 5;

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
    import dma_seq_pkg::*;
(
    input  logic [3:0] mode_in,
    output logic       reserved,
    output logic       io_paced
);
    addr_mode_e src_m;
    addr_mode_e dst_m;

    always_comb begin
        src_m    = addr_mode_e'(mode_in[1:0]);
        dst_m    = addr_mode_e'(mode_in[3:2]);
        // both sides fixed (memory or I/O) is not a legal pairing
        reserved = (src_m inside {AM_FIXMEM, AM_FIXIO}) && (dst_m inside {AM_FIXMEM, AM_FIXIO});
        io_paced = (src_m == AM_FIXIO) || (dst_m == AM_FIXIO);
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [1:0]        code,
    output logic [ADDR_W-1:0] addr_next
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        unique case (addr_mode_e'(code))
            AM_INC:  addr_next = addr_in + ONE;
            AM_DEC:  addr_next = addr_in - ONE;
            default: addr_next = addr_in;
        endcase
    end
endmodule

// File: rtl/dma_pace.sv
module dma_pace
    import dma_seq_pkg::*;
(
    input  logic       io_paced,
    input  logic       burst,
    input  logic       ext_req,
    output seq_state_e start_state,
    output seq_state_e next_byte_state
);
    always_comb begin
        start_state = io_paced ? ST_WAIT : ST_REQ;
        if (io_paced) begin
            next_byte_state = ext_req ? ST_READ : ST_WAIT;
        end else if (burst) begin
            next_byte_state = ST_READ;
        end else begin
            next_byte_state = ST_STEAL;
        end
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dma_req,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_mem,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              enable,
    output logic              burst_mode,
    output logic [3:0]        mode,
    output logic              mode_err,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count
);
    localparam int             N_SIDES  = 2;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        mode;
        logic              burst;
        logic              en;
        logic              err;
        logic [DATA_W-1:0] data;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    // decode the incoming control word while idle, the live mode otherwise
    logic [3:0] dec_mode;
    logic       dec_reserved;
    logic       dec_io_paced;

    assign dec_mode = (r_q.state == ST_IDLE) ? cfg_wdata[3:0] : r_q.mode;

    dma_mode_decode i_decode (
        .mode_in  (dec_mode),
        .reserved (dec_reserved),
        .io_paced (dec_io_paced)
    );

    logic       pace_burst;
    seq_state_e start_state;
    seq_state_e next_byte_state;

    assign pace_burst = r_q.burst;

    dma_pace i_pace (
        .io_paced        (dec_io_paced),
        .burst           (pace_burst),
        .ext_req         (dma_req),
        .start_state     (start_state),
        .next_byte_state (next_byte_state)
    );

    // one address stepper per side: index 0 source, index 1 destination
    logic [ADDR_W-1:0] side_addr [N_SIDES];
    logic [ADDR_W-1:0] side_next [N_SIDES];
    logic [1:0]        side_code [N_SIDES];

    assign side_addr[0] = r_q.src;
    assign side_addr[1] = r_q.dst;
    assign side_code[0] = r_q.mode[1:0];
    assign side_code[1] = r_q.mode[3:2];

    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        dma_addr_step #(.ADDR_W(ADDR_W)) i_step (
            .addr_in   (side_addr[g]),
            .code      (side_code[g]),
            .addr_next (side_next[g])
        );
    end

    logic src_is_io;
    logic dst_is_io;

    assign src_is_io = (addr_mode_e'(r_q.mode[1:0]) == AM_FIXIO);
    assign dst_is_io = (addr_mode_e'(r_q.mode[3:2]) == AM_FIXIO);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cfg_we) begin
                    unique case (cfg_sel)
                        SEL_SRC: r_d.src = cfg_wdata;
                        SEL_DST: r_d.dst = cfg_wdata;
                        SEL_CNT: r_d.cnt = cfg_wdata[CNT_W-1:0];
                        default: begin
                            r_d.mode  = cfg_wdata[3:0];
                            r_d.burst = cfg_wdata[CTRL_BURST_BIT];
                            if (cfg_wdata[CTRL_EN_BIT]) begin
                                if (dec_reserved) begin
                                    r_d.err = 1'b1;
                                end else if (r_q.cnt == CNT_ZERO) begin
                                    r_d.done = 1'b1;
                                end else begin
                                    r_d.en    = 1'b1;
                                    r_d.state = start_state;
                                end
                            end
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (dma_req) begin
                    r_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    r_d.state = ST_READ;
                end
            end
            ST_READ: begin
                r_d.data  = rd_data;
                r_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                r_d.src = side_next[0];
                r_d.dst = side_next[1];
                r_d.cnt = r_q.cnt - CNT_ONE;
                if (r_q.cnt == CNT_ONE) begin
                    r_d.en    = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.state = next_byte_state;
                end
            end
            ST_STEAL: begin
                r_d.state = ST_REQ;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, src: '0, dst: '0, cnt: '0, mode: '0,
                     burst: 1'b0, en: 1'b0, err: 1'b0, data: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_req  = (r_q.state == ST_REQ) || (r_q.state == ST_READ) || (r_q.state == ST_WRITE);
        bus_rd   = (r_q.state == ST_READ);
        bus_wr   = (r_q.state == ST_WRITE);
        bus_io   = (bus_rd && src_is_io) || (bus_wr && dst_is_io);
        bus_mem  = (bus_rd || bus_wr) && !bus_io;
        bus_addr = bus_rd ? r_q.src : (bus_wr ? r_q.dst : '0);
        wr_data  = bus_wr ? r_q.data : '0;
    end

    assign done       = r_q.done;
    assign enable     = r_q.en;
    assign burst_mode = r_q.burst;
    assign mode       = r_q.mode;
    assign mode_err   = r_q.err;
    assign src_addr   = r_q.src;
    assign dst_addr   = r_q.dst;
    assign count      = r_q.cnt;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              dma_req,
    input logic              bus_gnt,
    input logic              bus_req,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_mem,
    input logic              bus_io,
    input logic [DATA_W-1:0] wr_data,
    input logic              done,
    input logic              enable,
    input logic              burst_mode,
    input logic [3:0]        mode,
    input logic              mode_err,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  count
);
    logic io_run;
    assign io_run = (mode[3:2] == 2'b11) || (mode[1:0] == 2'b11);

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));

    p_space_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_io != bus_mem));

    p_err_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err) |-> (!bus_req && !enable));

    p_burst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !io_run && burst_mode && count > 1) |=> (bus_req && bus_rd));

    p_steal_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !io_run && !burst_mode && count > 1) |=> !bus_req);

    p_io_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && io_run && !bus_req && !dma_req) |=> !bus_req);

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (count == $past(count) - CNT_W'(1)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!enable && !bus_req));

    p_ignored_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$past(bus_wr)) |-> ($stable(src_addr) && $stable(dst_addr)));

    p_strobe_granted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_req && bus_gnt));

    logic unused_ok;
    assign unused_ok = cfg_we ^ (^wr_data);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .dma_req    (dma_req),
    .bus_gnt    (bus_gnt),
    .bus_req    (bus_req),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_mem    (bus_mem),
    .bus_io     (bus_io),
    .wr_data    (wr_data),
    .done       (done),
    .enable     (enable),
    .burst_mode (burst_mode),
    .mode       (mode),
    .mode_err   (mode_err),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .count      (count)
);

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
    localparam int N_BYTES = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [19:0] cfg_wdata = '0;
    logic        dma_req = 1'b0;
    logic        bus_gnt;
    logic [7:0]  rd_data;
    logic        bus_req, bus_rd, bus_wr, bus_mem, bus_io, done, enable, burst_mode, mode_err;
    logic [19:0] bus_addr, src_addr, dst_addr;
    logic [7:0]  wr_data;
    logic [3:0]  mode;
    logic [15:0] count;

    always #5 clk = ~clk;

    dma_xfer_seq i_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dma_req(dma_req), .bus_gnt(bus_gnt), .rd_data(rd_data),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_mem(bus_mem), .bus_io(bus_io),
        .bus_addr(bus_addr), .wr_data(wr_data), .done(done), .enable(enable),
        .burst_mode(burst_mode), .mode(mode), .mode_err(mode_err),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count)
    );

    // grant follows request one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_gnt <= 1'b0;
        else        bus_gnt <= bus_req;
    end

    function automatic logic [7:0] src_byte(input logic [19:0] a, input logic io);
        return a[7:0] ^ (io ? 8'hA5 : 8'h3C);
    endfunction

    assign rd_data = src_byte(bus_addr, bus_io);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] step_of(input logic [1:0] code);
        case (code)
            2'b00:   return 20'h00001;
            2'b01:   return 20'hFFFFF;
            default: return 20'h00000;
        endcase
    endfunction

    // run context used by the monitor
    logic [19:0] s0, d0;
    logic [3:0]  cur_mode;
    bit          active = 0;
    int          byte_k, rises, lows, dones;
    bit          prev_req, seen_rise;

    function automatic logic [19:0] exp_src(input int k);
        return s0 + step_of(cur_mode[1:0]) * 20'(k);
    endfunction
    function automatic logic [19:0] exp_dst(input int k);
        return d0 + step_of(cur_mode[3:2]) * 20'(k);
    endfunction

    always @(negedge clk) begin
        if (active) begin
            if (bus_req && !prev_req) begin
                rises++;
                seen_rise = 1;
            end
            if (seen_rise && !bus_req && !done && byte_k < N_BYTES) lows++;
            prev_req = bus_req;
            if (done) dones++;
            if (bus_rd || bus_wr) chk(bus_gnt && bus_req, "R11", {30'd0, bus_req, bus_gnt}, 32'd3);
            if (bus_rd) begin
                chk(bus_addr == exp_src(byte_k), "R2 src addr", bus_addr, exp_src(byte_k));
                chk(bus_io == (cur_mode[1:0] == 2'b11) && bus_mem == !bus_io, "R3 src space",
                    {30'd0, bus_io, bus_mem}, {30'd0, cur_mode[1:0] == 2'b11, cur_mode[1:0] != 2'b11});
            end
            if (bus_wr) begin
                chk(bus_addr == exp_dst(byte_k), "R2 dst addr", bus_addr, exp_dst(byte_k));
                chk(wr_data == src_byte(exp_src(byte_k), cur_mode[1:0] == 2'b11), "R3 data",
                    wr_data, src_byte(exp_src(byte_k), cur_mode[1:0] == 2'b11));
                chk(bus_io == (cur_mode[3:2] == 2'b11) && bus_mem == !bus_io, "R3 dst space",
                    {30'd0, bus_io, bus_mem}, {30'd0, cur_mode[3:2] == 2'b11, cur_mode[3:2] != 2'b11});
                byte_k++;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [19:0] val);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!enable && !burst_mode && !mode_err && !bus_req && !bus_rd && !bus_wr && !bus_io && !bus_mem && !done,
            "R1 reset", {23'd0, enable, burst_mode, mode_err, bus_req, bus_rd, bus_wr, bus_io, bus_mem, done}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic arm_monitor();
        byte_k = 0; rises = 0; lows = 0; dones = 0;
        prev_req = 0; seen_rise = 0;
        active = 1;
    endtask

    task automatic run_case(input logic [3:0] m, input logic burst);
        bit rsv, io, steal;
        int wd;
        rsv   = m[3] && m[1];
        io    = (m[3:2] == 2'b11) || (m[1:0] == 2'b11);
        steal = !io && !burst;
        do_reset();
        s0 = 20'h00105 + 20'(m);
        d0 = 20'h00001;
        cur_mode = m;
        dma_req = !io;
        cfg_write(2'd0, s0);
        cfg_write(2'd1, d0);
        cfg_write(2'd2, 20'(N_BYTES));
        arm_monitor();
        cfg_write(2'd3, {14'd0, 1'b1, burst, m});
        if (rsv) begin
            repeat (4) begin
                @(negedge clk);
                chk(!bus_req && !bus_rd && !bus_wr, "R4 no bus", {31'd0, bus_req}, 32'd0);
            end
            chk(mode_err && !enable, "R4 flag", {30'd0, mode_err, enable}, 32'd2);
            cfg_write(2'd3, 20'h00000);
            @(negedge clk);
            chk(mode_err == 1'b1, "R4 sticky", {31'd0, mode_err}, 32'd1);
            chk(count == 16'(N_BYTES) && byte_k == 0, "R4 no transfer", count, N_BYTES);
            active = 0;
            return;
        end
        if (io) begin
            repeat (6) begin
                @(negedge clk);
                chk(!bus_req && !bus_rd && !bus_wr, "R8 paced wait", {31'd0, bus_req}, 32'd0);
            end
            cfg_write(2'd0, 20'hABCDE);
            cfg_write(2'd2, 20'h00009);
            @(negedge clk);
            chk(src_addr == s0 && count == 16'(N_BYTES), "R10 write ignored", src_addr, s0);
            dma_req = 1'b1;
        end
        wd = 0;
        while (dones == 0 && wd < 200) begin
            @(negedge clk);
            wd++;
        end
        repeat (3) @(negedge clk);
        active = 0;
        chk(byte_k == N_BYTES, "R9 byte count", byte_k, N_BYTES);
        chk(dones == 1, "R9 done pulse", dones, 1);
        chk(count == 16'd0 && !enable && !bus_req, "R9 end state", {count, 15'd0, enable}, 32'd0);
        chk(src_addr == exp_src(N_BYTES), "R2 final src", src_addr, exp_src(N_BYTES));
        chk(dst_addr == exp_dst(N_BYTES), "R2 final dst", dst_addr, exp_dst(N_BYTES));
        if (steal) begin
            chk(rises == N_BYTES, "R7 request rises", rises, N_BYTES);
            chk(lows == N_BYTES - 1, "R7 gap cycles", lows, N_BYTES - 1);
        end else if (!io) begin
            chk(rises == 1, "R6 request rises", rises, 1);
            chk(lows == 0, "R6 gap cycles", lows, 0);
        end else begin
            chk(rises == 1 && lows == 0, "R8 burst bit ignored", rises, 1);
        end
    endtask

    task automatic zero_count_case();
        do_reset();
        cfg_write(2'd2, 20'd0);
        arm_monitor();
        cfg_write(2'd3, {14'd0, 1'b1, 1'b1, 4'b0000});
        repeat (5) @(negedge clk);
        active = 0;
        chk(dones == 1, "R5 done pulse", dones, 1);
        chk(rises == 0 && !enable, "R5 no bus", rises, 0);
    endtask

    initial begin
        for (int m = 0; m < 16; m++) begin
            for (int b = 0; b < 2; b++) begin
                run_case(4'(m), 1'(b));
            end
        end
        zero_count_case();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule